// File: doc/BRIEF.md
# Dual-Edge Hit Time-Stamping Converter

This block assigns arrival times to the pulses of a discriminator at the bottom of a detector column. The pulses are not tied to any clock. Time is kept in two parts. A coarse binary counter advances on every cycle of a fast clock. A fine phase comes from a snapshot of a tapped delay line that is locked so that its taps together span exactly one fast-clock period. The snapshot is a thermometer code. It is reduced to a fine index and appended below the coarse count to form one time word.

Each pulse is measured twice: once at its leading edge and once at its trailing edge. When the trailing edge has been measured, the block loads a result register with three values: the leading time, the trailing time and their difference. The difference is the time over threshold, which later stages use to correct amplitude-dependent walk. A consumer drains the result register with a valid/ready handshake. A pulse that starts while an earlier result is still waiting is not measured, and a sticky flag records the loss.

Top module: `edge_tdc`

## Requirements
- R1: While reset is held and on release, `res_valid_o` and `overflow_o` are 0.
- R2: The coarse count is 0 during reset and rises by one on every clock edge after release, wrapping modulo 128. A time word carries the coarse count in bits 11:5 and the fine code in bits 4:0.
- R3: The fine code is the position just above the lowest tap `k` where tap `k` is 1 and taps `k+1` and `k+2` are 0 (taps above bit 31 read as 0). Tap 0 is the earliest tap. An all-zero snapshot gives 0, a clean code with `n` ones at the bottom gives `n`, and an all-ones snapshot gives 31.
- R4: A single 0 inside the run of ones, including one at tap 0, does not change the fine code.
- R5: An edge of `hit_i` that is first sampled at clock edge `e` is time-stamped at edge `e+2`. It uses the coarse count held just before that edge and the tap vector present at that edge.
- R6: Every measured pulse yields exactly one result, which appears after its trailing edge has been time-stamped. The result carries the leading time in `lead_ts_o` and the trailing time in `trail_ts_o`.
- R7: `tot_o` equals trailing time minus leading time modulo 4096, so the width is correct even when the coarse count wraps during the pulse.
- R8: While `res_valid_o` is 1 and `res_ready_i` is 0, the valid flag and all three result fields hold their values on the next cycle.
- R9: A leading edge that is time-stamped while a result is pending and not being accepted is dropped. That pulse produces no result, and `overflow_o` goes to 1 and stays at 1 until reset.
- R10: A leading edge time-stamped in the same cycle in which the pending result is accepted is measured normally and does not set `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the coarse counter and all logic |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Asynchronous discriminator output; high for the time over threshold |
| taps_i | input | 32 | Delay-line tap snapshot, thermometer code, tap 0 earliest |
| res_ready_i | input | 1 | Consumer accepts the result register |
| res_valid_o | output | 1 | Result register holds an unread measurement |
| lead_ts_o | output | 12 | Leading-edge time {coarse, fine} |
| trail_ts_o | output | 12 | Trailing-edge time {coarse, fine} |
| tot_o | output | 12 | Time over threshold, modulo 4096 |
| overflow_o | output | 1 | Sticky flag: a pulse was dropped |

## Verification
The assertions rely on three assumptions about the inputs. The tap vector is steady at the edge where a hit edge is time-stamped. The hit input stays high and low long enough for the synchronizer to see each edge. Once the result register is loaded, it changes only through the handshake. The bench changes `hit_i`, `taps_i` and `res_ready_i` only on falling clock edges, so each value is settled at the sampling edges. Tap snapshots stay unchanged for at least three cycles after every hit edge. In the one back-to-back case, where the low gap lasts a single cycle, the trailing snapshot and the next leading snapshot are the same vector.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    localparam int TAPS_DEF        = 32;
    localparam int COARSE_W_DEF    = 7;
    localparam int SYNC_STAGES_DEF = 2;

    // Measurement sequencer states
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a leading edge
        ST_HIGH = 2'd1,   // leading time held, waiting for trailing edge
        ST_DROP = 2'd2    // pulse rejected, waiting for its trailing edge
    } meas_state_e;

    // Edge events from the synchronizer
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

endpackage

// File: rtl/tdc_sync.sv
module tdc_sync
    import tdc_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      async_i,
    output edge_evt_t evt_o
);

    // chain[0..STAGES-1] is the synchronizer, chain[STAGES] the delayed copy
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-1:0], async_i};
        end
    end

    always_comb begin
        evt_o.rise = chain[STAGES-1] & ~chain[STAGES];
        evt_o.fall = ~chain[STAGES-1] & chain[STAGES];
    end

endmodule

// File: rtl/tdc_therm_enc.sv
module tdc_therm_enc #(
    parameter int TAPS   = 32,
    parameter int FINE_W = $clog2(TAPS)
) (
    input  logic [TAPS-1:0]   taps_i,
    output logic [FINE_W-1:0] fine_o
);

    // Two zero bits above the top tap so the edge test never indexes out
    logic [TAPS+1:0] ext;
    logic            found;

    assign ext = {2'b00, taps_i};

    // A real edge is a 1 followed by two 0s; a lone 0 is treated as a bubble
    always_comb begin
        fine_o = FINE_W'(TAPS - 1);
        found  = 1'b0;
        if (!ext[0] && !ext[1]) begin
            fine_o = '0;
            found  = 1'b1;
        end
        for (int i = 0; i < TAPS - 1; i++) begin
            if (!found && ext[i] && !ext[i+1] && !ext[i+2]) begin
                fine_o = FINE_W'(i + 1);
                found  = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tdc_measure.sv
module tdc_measure
    import tdc_pkg::*;
#(
    parameter int TS_W = 12
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            rise_i,
    input  logic            fall_i,
    input  logic [TS_W-1:0] ts_i,
    input  logic            ready_i,
    output logic            valid_o,
    output logic [TS_W-1:0] lead_o,
    output logic [TS_W-1:0] trail_o,
    output logic [TS_W-1:0] tot_o,
    output logic            ovf_o
);

    meas_state_e     state;
    logic [TS_W-1:0] lead_q;
    logic            pending;

    assign pending = valid_o & ~ready_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            lead_q  <= '0;
            valid_o <= 1'b0;
            lead_o  <= '0;
            trail_o <= '0;
            tot_o   <= '0;
            ovf_o   <= 1'b0;
        end else begin
            if (valid_o && ready_i) begin
                valid_o <= 1'b0;
            end
            unique case (state)
                ST_IDLE: begin
                    if (rise_i) begin
                        if (pending) begin
                            ovf_o <= 1'b1;
                            state <= ST_DROP;
                        end else begin
                            lead_q <= ts_i;
                            state  <= ST_HIGH;
                        end
                    end
                end
                ST_HIGH: begin
                    if (fall_i) begin
                        lead_o  <= lead_q;
                        trail_o <= ts_i;
                        tot_o   <= ts_i - lead_q;   // modulo 2^TS_W
                        valid_o <= 1'b1;
                        state   <= ST_IDLE;
                    end
                end
                ST_DROP: begin
                    if (fall_i) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
        valid_o && !ready_i |=> valid_o && $stable(lead_o) && $stable(trail_o) && $stable(tot_o)); // R8

    AST_DROP_FLAG: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE && rise_i && valid_o && !ready_i |=> ovf_o); // R9

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_o |=> ovf_o); // R9

    AST_LOAD_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        state == ST_HIGH && fall_i |=> valid_o); // R6

    AST_EDGE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(rise_i && fall_i)); // R5

    AST_ACCEPT_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        state == ST_IDLE && rise_i && !ovf_o && (!valid_o || ready_i) |=> !ovf_o); // R10

endmodule

// File: rtl/edge_tdc.sv
module edge_tdc
    import tdc_pkg::*;
#(
    parameter int TAPS        = TAPS_DEF,
    parameter int COARSE_W    = COARSE_W_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int FINE_W     = $clog2(TAPS),
    localparam int TS_W       = COARSE_W + FINE_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit_i,
    input  logic [TAPS-1:0] taps_i,
    input  logic            res_ready_i,
    output logic            res_valid_o,
    output logic [TS_W-1:0] lead_ts_o,
    output logic [TS_W-1:0] trail_ts_o,
    output logic [TS_W-1:0] tot_o,
    output logic            overflow_o
);

    logic [COARSE_W-1:0] coarse_q;
    logic [FINE_W-1:0]   fine;
    logic [TS_W-1:0]     ts_now;
    edge_evt_t           evt;

    // Free-running coarse counter on the fast clock
    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_q <= '0;
        end else begin
            coarse_q <= coarse_q + 1'b1;
        end
    end

    AST_COARSE_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> coarse_q == $past(coarse_q) + COARSE_W'(1)); // R2

    tdc_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (hit_i),
        .evt_o   (evt)
    );

    tdc_therm_enc #(
        .TAPS   (TAPS),
        .FINE_W (FINE_W)
    ) u_enc (
        .taps_i (taps_i),
        .fine_o (fine)
    );

    assign ts_now = {coarse_q, fine};

    tdc_measure #(
        .TS_W (TS_W)
    ) u_meas (
        .clk     (clk),
        .rst     (rst),
        .rise_i  (evt.rise),
        .fall_i  (evt.fall),
        .ts_i    (ts_now),
        .ready_i (res_ready_i),
        .valid_o (res_valid_o),
        .lead_o  (lead_ts_o),
        .trail_o (trail_ts_o),
        .tot_o   (tot_o),
        .ovf_o   (overflow_o)
    );

endmodule

// File: tb/edge_tdc_tb.sv
module edge_tdc_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        hit;
    logic [31:0] taps;
    logic        ready;
    logic        valid;
    logic [11:0] lead_ts;
    logic [11:0] trail_ts;
    logic [11:0] tot;
    logic        ovf;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [11:0] lead;
        logic [11:0] trail;
        logic [11:0] tot;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;   // 250 MHz

    edge_tdc u_dut (
        .clk         (clk),
        .rst         (rst),
        .hit_i       (hit),
        .taps_i      (taps),
        .res_ready_i (ready),
        .res_valid_o (valid),
        .lead_ts_o   (lead_ts),
        .trail_ts_o  (trail_ts),
        .tot_o       (tot),
        .overflow_o  (ovf)
    );

    // Elapsed clock edges since reset release (R2 timebase)
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    function automatic logic [31:0] therm(input int n);
        if (n >= 32) return '1;
        return (32'd1 << n) - 32'd1;
    endfunction

    function automatic logic [11:0] mk_ts(input int c, input int f);
        logic [6:0] cc;
        logic [4:0] ff;
        cc = 7'(c % 128);
        ff = 5'(f);
        return {cc, ff};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Driver: one pulse; pushes its expected result when it should be measured
    task automatic pulse(input logic [31:0] tl, input int fl,
                         input logic [31:0] tt, input int ft,
                         input int width, input int gap, input bit expect_res);
        int n;
        int m;
        exp_t e;
        @(negedge clk);
        hit  = 1'b1;
        taps = tl;
        n    = cyc;
        repeat (width) @(negedge clk);
        hit  = 1'b0;
        taps = tt;
        m    = cyc;
        if (expect_res) begin
            e.lead  = mk_ts(n + 2, fl);   // R5: two sync stages then capture
            e.trail = mk_ts(m + 2, ft);
            e.tot   = e.trail - e.lead;   // R7: modulo 4096
            exp_q.push_back(e);
        end
        repeat (gap) @(negedge clk);
    endtask

    // Monitor / scoreboard
    initial begin
        bit          stalled = 1'b0;
        logic [11:0] s_lead, s_trail, s_tot;
        forever begin
            @(negedge clk);
            #1;
            if (rst || done) begin
                stalled = 1'b0;
            end else begin
                if (stalled) begin
                    check(valid === 1'b1, "R8", "valid held during stall", 32'(valid), 32'd1);
                    check(lead_ts === s_lead && trail_ts === s_trail && tot === s_tot,
                          "R8", "result stable during stall", 32'(lead_ts), 32'(s_lead));
                end
                if (valid) begin
                    if (ready) begin
                        if (exp_q.size() == 0) begin
                            check(1'b0, "R9", "unexpected result", 32'(lead_ts), 32'd0);
                        end else begin
                            exp_t e;
                            e = exp_q.pop_front();
                            check(lead_ts === e.lead, "R6", "leading time", 32'(lead_ts), 32'(e.lead));
                            check(trail_ts === e.trail, "R6", "trailing time", 32'(trail_ts), 32'(e.trail));
                            check(tot === e.tot, "R7", "time over threshold", 32'(tot), 32'(e.tot));
                        end
                        stalled = 1'b0;
                    end else begin
                        stalled = 1'b1;
                        s_lead  = lead_ts;
                        s_trail = trail_ts;
                        s_tot   = tot;
                    end
                end else begin
                    stalled = 1'b0;
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst   = 1'b1;
        hit   = 1'b0;
        taps  = '0;
        ready = 1'b1;
        repeat (5) @(negedge clk);
        #1;
        check(valid === 1'b0, "R1", "valid in reset", 32'(valid), 32'd0);
        check(ovf === 1'b0, "R1", "overflow in reset", 32'(ovf), 32'd0);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // R3 / R5 / R6: clean thermometer codes
        pulse(therm(5), 5, therm(20), 20, 10, 6, 1'b1);
        pulse(therm(1), 1, therm(31), 31, 4, 6, 1'b1);
        // R3: all-zero gives 0, all-ones gives 31
        pulse(32'h0, 0, 32'hFFFF_FFFF, 31, 7, 6, 1'b1);
        // R4: single-bit bubbles inside the ones, at tap 0, and at the top of the run
        pulse(therm(12) & ~(32'd1 << 6), 12, therm(25) & ~32'd1, 25, 5, 6, 1'b1);
        pulse(therm(9) | (32'd1 << 10), 11, therm(3) & ~32'd2, 3, 6, 6, 1'b1);
        // R7: long pulses spanning coarse wrap
        pulse(therm(30), 30, therm(2), 2, 90, 5, 1'b1);
        pulse(therm(8), 8, therm(17), 17, 100, 5, 1'b1);
        pulse(therm(0), 0, therm(29), 29, 120, 5, 1'b1);

        // R8: consumer stalls
        ready = 1'b0;
        pulse(therm(3), 3, therm(30), 30, 5, 4, 1'b1);
        repeat (4) @(negedge clk);
        #1;
        check(valid === 1'b1, "R8", "result waits while stalled", 32'(valid), 32'd1);
        @(negedge clk);
        ready = 1'b1;
        repeat (3) @(negedge clk);

        // R10: next leading edge in the cycle the result is accepted
        pulse(therm(7), 7, therm(14), 14, 4, 0, 1'b1);
        pulse(therm(14), 14, therm(2), 2, 4, 6, 1'b1);
        #1;
        check(ovf === 1'b0, "R10", "no overflow on accepting cycle", 32'(ovf), 32'd0);

        // R9: pulse while result pending is dropped
        ready = 1'b0;
        pulse(therm(10), 10, therm(21), 21, 4, 6, 1'b1);
        pulse(therm(4), 4, therm(6), 6, 4, 6, 1'b0);
        #1;
        check(ovf === 1'b1, "R9", "overflow after dropped pulse", 32'(ovf), 32'd1);
        @(negedge clk);
        ready = 1'b1;
        repeat (12) @(negedge clk);
        #1;
        check(valid === 1'b0, "R9", "no result for dropped pulse", 32'(valid), 32'd0);
        check(exp_q.size() == 0, "R6", "all measured pulses delivered", 32'(exp_q.size()), 32'd0);
        pulse(therm(16), 16, therm(19), 19, 5, 8, 1'b1);
        #1;
        check(ovf === 1'b1, "R9", "overflow stays set", 32'(ovf), 32'd1);

        repeat (10) @(negedge clk);
        check(exp_q.size() == 0, "R6", "queue drained at end", 32'(exp_q.size()), 32'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule